// File: doc/BRIEF.md
# Floating-Point Result Renormalizer

This block sits between the significand adder and the rounding stage of a floating-point add/subtract pipeline. It receives the raw non-negative sum of the aligned significands. The sum has two integer bits, so a carry can land above the binary point, followed by the fraction and guard bits. It also receives the exponent of the larger operand. It returns a significand with one integer bit and the same fraction and guard bits, a sticky bit, the adjusted exponent, and three indications: zero, denormal and exponent overflow.

The block picks one of five significand actions: keep, shift right by one, shift left to the leading one, shift left then right by one, or force zero. It pairs that with one of four exponent actions: keep, increment, decrease by the shift, or force zero. A combinational leading-one detector sets the left-shift distance in one pass. That distance is clamped so the exponent never drops below one, and an input that cannot be fully normalized leaves as a denormal with exponent field 0. An exponent field of 0 on the input carries the same scale as a field of 1, so sums of denormals pass through or reach the smallest normal without special treatment. The result is registered: one cycle after `in_valid`, the outputs carry the result. They hold their values while `in_valid` is low. Rounding is done downstream.

Top module: `fp_renorm`

## Requirements
- R1: The outputs update on the clock edge on which `in_valid` is 1, and `out_valid` is 1 in the following cycle. When `in_valid` is 0, `out_valid` falls to 0 and `out_sig` and `out_exp` keep their previous values.
- R2: An all-zero `in_sum` gives `out_sig`=0, `out_exp`=0, `out_sticky`=0 and `out_zero`=1.
- R3: When bit W_IN-1 of `in_sum` (weight 2) is 1, `out_sig` is `in_sum` shifted right by one with its top bit dropped. `out_sticky` is bit 0 of `in_sum`, and `out_exp` is Eeff+1. Eeff is `in_exp`, except that Eeff is 1 when `in_exp` is 0.
- R4: If in the R3 case Eeff+1 is at least 2^EXP_W-1, then `out_exp` is all ones and `out_ovf` is 1. `out_ovf` is 0 in every other case.
- R5: When the top two bits of `in_sum` are 01, `out_sig` is the low W_IN-1 bits of `in_sum`, `out_exp` is Eeff and `out_sticky` is 0.
- R6: When the top two bits are 00 and the sum is non-zero, let L be the number of zero bits above the leading one, counted from bit W_IN-2. If L is at most Eeff-1, `out_sig` is the low bits shifted left by L, with bit W_OUT-1 set, and `out_exp` is Eeff-L.
- R7: When in the R6 case L exceeds Eeff-1, `out_sig` is the low bits shifted left by Eeff-1, with bit W_OUT-1 clear. `out_exp` is 0 and `out_denorm` is 1.
- R8: An `in_exp` of 0 acts as scale 1. A sum of form 00.x then leaves unchanged with `out_exp`=0 and `out_denorm`=1, and a sum of form 01.x leaves with `out_exp`=1.
- R9: At most one of `out_zero`, `out_denorm` and `out_ovf` is 1. `out_denorm` implies `out_exp`=0 and a non-zero `out_sig`.
- R10: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Load a new sum this cycle |
| in_sum | input | W_IN = 2+FRAC_W+GRD_W | Raw sum, binary point below bit W_IN-2 |
| in_exp | input | EXP_W | Exponent of the larger operand |
| out_valid | output | 1 | Registered result present |
| out_sig | output | W_OUT = 1+FRAC_W+GRD_W | Normalized significand, bit W_OUT-1 is the integer bit |
| out_sticky | output | 1 | OR of all bits shifted out |
| out_exp | output | EXP_W | Adjusted exponent |
| out_zero | output | 1 | Exact zero result |
| out_denorm | output | 1 | Result is denormal |
| out_ovf | output | 1 | Exponent increment reached the all-ones code |

## Verification
The bench sweeps every 8-bit sum against every 5-bit exponent in a small configuration. This covers carry-out sums, sums that are already normal, and every depth of cancellation. Exponents 0 and 1 separate the scale-1 treatment of a zero field from the clamped left shift. Small exponents against deep cancellation show where the shift stops and the denormal encoding begins. The top exponents show whether the overflow indication comes only from the increment path. A closing step with `in_valid` low shows whether the registered result holds.

// File: rtl/fp_renorm_pkg.sv
package fp_renorm_pkg;

    typedef enum logic [2:0] {
        MA_KEEP    = 3'd0,
        MA_RSH1    = 3'd1,
        MA_LSH     = 3'd2,
        MA_LSH_RSH = 3'd3,
        MA_ZERO    = 3'd4
    } man_act_e;

    typedef enum logic [1:0] {
        EA_KEEP = 2'd0,
        EA_INC  = 2'd1,
        EA_DEC  = 2'd2,
        EA_ZERO = 2'd3
    } exp_act_e;

endpackage

// File: rtl/fp_renorm_lod.sv
module fp_renorm_lod #(
    parameter int W   = 56,
    parameter int LZW = 6
) (
    input  logic [W-1:0]   vec,
    output logic [LZW-1:0] lz,
    output logic           any
);
    // Scans from the LSB upward so the highest set bit wins.
    always_comb begin
        lz  = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                lz  = LZW'(W - 1 - i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fp_renorm_ctrl.sv
module fp_renorm_ctrl
    import fp_renorm_pkg::*;
#(
    parameter int EXP_W = 11,
    parameter int LZW   = 6
) (
    input  logic             carry,
    input  logic             unit,
    input  logic             nz,
    input  logic [EXP_W-1:0] exp_in,
    input  logic [LZW-1:0]   lz,
    output man_act_e         man_act,
    output exp_act_e         exp_act,
    output logic [LZW-1:0]   sh_amt,
    output logic [EXP_W-1:0] exp_out,
    output logic             ovf,
    output logic             denorm
);
    localparam int CW = ((EXP_W > LZW) ? EXP_W : LZW) + 1;
    localparam logic [EXP_W-1:0] EMAX = '1;

    logic [EXP_W-1:0] eeff;
    logic [CW-1:0]    eeff_x;
    logic [CW-1:0]    lz_x;
    logic [CW-1:0]    lim_x;
    logic [CW-1:0]    inc_x;

    always_comb begin
        eeff   = (exp_in == '0) ? EXP_W'(1) : exp_in;
        eeff_x = CW'(eeff);
        lz_x   = CW'(lz);
        lim_x  = eeff_x - CW'(1);
        inc_x  = eeff_x + CW'(1);

        man_act = MA_KEEP;
        exp_act = EA_KEEP;
        sh_amt  = '0;
        exp_out = eeff;
        ovf     = 1'b0;
        denorm  = 1'b0;

        if (!nz) begin
            man_act = MA_ZERO;
            exp_act = EA_ZERO;
            exp_out = '0;
        end else if (carry) begin
            man_act = MA_RSH1;
            exp_act = EA_INC;
            if (inc_x >= CW'(EMAX)) begin
                exp_out = EMAX;
                ovf     = 1'b1;
            end else begin
                exp_out = EXP_W'(inc_x);
            end
        end else if (unit) begin
            man_act = MA_KEEP;
            exp_act = EA_KEEP;
        end else if (lz_x <= lim_x) begin
            man_act = MA_LSH;
            exp_act = EA_DEC;
            sh_amt  = lz;
            exp_out = EXP_W'(eeff_x - lz_x);
        end else begin
            // Left by Eeff, then right by one: net Eeff-1, exponent code 0.
            man_act = MA_LSH_RSH;
            exp_act = EA_ZERO;
            sh_amt  = LZW'(eeff);
            exp_out = '0;
            denorm  = 1'b1;
        end
    end
endmodule

// File: rtl/fp_renorm_shift.sv
module fp_renorm_shift
    import fp_renorm_pkg::*;
#(
    parameter int W   = 56,
    parameter int LZW = 6
) (
    input  logic           top_bit,
    input  logic [W-1:0]   lo,
    input  man_act_e       man_act,
    input  logic [LZW-1:0] sh_amt,
    output logic [W-1:0]   sig,
    output logic           sticky
);
    logic [W-1:0]   stg [0:LZW];
    logic [LZW-1:0] lost;

    assign stg[0] = lo;

    for (genvar k = 0; k < LZW; k++) begin : g_stage
        localparam int SH = 1 << k;
        if (SH < W) begin : g_part
            assign stg[k+1] = sh_amt[k] ? {stg[k][W-1-SH:0], {SH{1'b0}}} : stg[k];
            assign lost[k]  = sh_amt[k] & (|stg[k][W-1 -: SH]);
        end else begin : g_all
            assign stg[k+1] = sh_amt[k] ? '0 : stg[k];
            assign lost[k]  = sh_amt[k] & (|stg[k]);
        end
    end

    always_comb begin
        sig    = '0;
        sticky = 1'b0;
        unique case (man_act)
            MA_KEEP: begin
                sig = lo;
            end
            MA_RSH1: begin
                sig    = {top_bit, lo[W-1:1]};
                sticky = lo[0];
            end
            MA_LSH: begin
                sig    = stg[LZW];
                sticky = |lost;
            end
            MA_LSH_RSH: begin
                sig    = {1'b0, stg[LZW][W-1:1]};
                sticky = (|lost) | stg[LZW][0];
            end
            default: begin
                sig    = '0;
                sticky = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fp_renorm.sv
module fp_renorm
    import fp_renorm_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    parameter int GRD_W  = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [2+FRAC_W+GRD_W-1:0]   in_sum,
    input  logic [EXP_W-1:0]            in_exp,
    output logic                        out_valid,
    output logic [1+FRAC_W+GRD_W-1:0]   out_sig,
    output logic                        out_sticky,
    output logic [EXP_W-1:0]            out_exp,
    output logic                        out_zero,
    output logic                        out_denorm,
    output logic                        out_ovf
);
    localparam int W_IN  = 2 + FRAC_W + GRD_W;
    localparam int W_OUT = W_IN - 1;
    localparam int LZW   = $clog2(W_OUT);
    localparam logic [EXP_W-1:0] EMAX = '1;

    typedef struct packed {
        logic             valid;
        logic [W_OUT-1:0] sig;
        logic             sticky;
        logic [EXP_W-1:0] exp;
        logic             zero;
        logic             denorm;
        logic             ovf;
    } st_t;

    st_t st_d, st_q;

    logic [LZW-1:0]   lz;
    logic             lo_any;
    logic             nz;
    man_act_e         man_act;
    exp_act_e         exp_act;
    logic [LZW-1:0]   sh_amt;
    logic [EXP_W-1:0] exp_new;
    logic             ovf_new;
    logic             den_new;
    logic [W_OUT-1:0] sig_new;
    logic             stk_new;

    fp_renorm_lod #(.W(W_OUT), .LZW(LZW)) u_lod (
        .vec (in_sum[W_OUT-1:0]),
        .lz  (lz),
        .any (lo_any)
    );

    assign nz = in_sum[W_IN-1] | lo_any;

    fp_renorm_ctrl #(.EXP_W(EXP_W), .LZW(LZW)) u_ctrl (
        .carry   (in_sum[W_IN-1]),
        .unit    (in_sum[W_IN-2]),
        .nz      (nz),
        .exp_in  (in_exp),
        .lz      (lz),
        .man_act (man_act),
        .exp_act (exp_act),
        .sh_amt  (sh_amt),
        .exp_out (exp_new),
        .ovf     (ovf_new),
        .denorm  (den_new)
    );

    fp_renorm_shift #(.W(W_OUT), .LZW(LZW)) u_shift (
        .top_bit (in_sum[W_IN-1]),
        .lo      (in_sum[W_OUT-1:0]),
        .man_act (man_act),
        .sh_amt  (sh_amt),
        .sig     (sig_new),
        .sticky  (stk_new)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.sig    = sig_new;
            st_d.sticky = stk_new;
            st_d.exp    = exp_new;
            st_d.zero   = (exp_act == EA_ZERO) && (man_act == MA_ZERO);
            st_d.denorm = den_new;
            st_d.ovf    = ovf_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_sig    = st_q.sig;
    assign out_sticky = st_q.sticky;
    assign out_exp    = st_q.exp;
    assign out_zero   = st_q.zero;
    assign out_denorm = st_q.denorm;
    assign out_ovf    = st_q.ovf;

    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_sig) && $stable(out_exp) && !out_valid));

    p_zero_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sum == '0) |=> (out_zero && out_sig == '0 && out_exp == '0 && !out_sticky));

    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sum[W_IN-1]) |=> (out_sig[W_OUT-1] && out_sticky == $past(in_sum[0])));

    p_ovf_exp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> out_exp == EMAX);

    p_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sum[W_IN-1:W_IN-2] == 2'b01) |=> (out_sig == $past(in_sum[W_OUT-1:0]) && !out_sticky));

    p_norm_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_zero && !out_denorm) |-> out_sig[W_OUT-1]);

    p_denorm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_denorm |-> (out_exp == '0 && !out_sig[W_OUT-1] && out_sig != '0));

    p_exp0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_exp == '0 && in_sum[W_IN-1:W_IN-2] == 2'b00 && in_sum != '0) |=> out_denorm);

    p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_zero, out_denorm, out_ovf}));
endmodule

// File: tb/sim_fp_renorm.sv
`timescale 1ns/1ps
module sim_fp_renorm;
    localparam int EXP_W  = 5;
    localparam int FRAC_W = 4;
    localparam int GRD_W  = 2;
    localparam int W_IN   = 2 + FRAC_W + GRD_W;
    localparam int W_OUT  = W_IN - 1;
    localparam int EMAX   = (1 << EXP_W) - 1;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [W_IN-1:0]     in_sum = '0;
    logic [EXP_W-1:0]    in_exp = '0;
    logic                out_valid;
    logic [W_OUT-1:0]    out_sig;
    logic                out_sticky;
    logic [EXP_W-1:0]    out_exp;
    logic                out_zero;
    logic                out_denorm;
    logic                out_ovf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fp_renorm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .GRD_W(GRD_W)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sum     (in_sum),
        .in_exp     (in_exp),
        .out_valid  (out_valid),
        .out_sig    (out_sig),
        .out_sticky (out_sticky),
        .out_exp    (out_exp),
        .out_zero   (out_zero),
        .out_denorm (out_denorm),
        .out_ovf    (out_ovf)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic check_all(input string req, input int vld, input int sig, input int stk,
                             input int ex, input int zr, input int dn, input int ov);
        checks++;
        if (int'(out_valid) != vld || int'(out_sig) != sig || int'(out_sticky) != stk ||
            int'(out_exp) != ex || int'(out_zero) != zr || int'(out_denorm) != dn ||
            int'(out_ovf) != ov) begin
            errors++;
            $display("FAIL %s: got v=%0d sig=%0h st=%0d e=%0d z=%0d d=%0d o=%0d exp v=%0d sig=%0h st=%0d e=%0d z=%0d d=%0d o=%0d (sum=%0h exp_in=%0d)",
                     req, out_valid, out_sig, out_sticky, out_exp, out_zero, out_denorm, out_ovf,
                     vld, sig, stk, ex, zr, dn, ov, in_sum, in_exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        int last_sig = 0;
        int last_exp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R10", 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;

        for (int e = 0; e <= EMAX; e++) begin
            for (int s = 0; s < (1 << W_IN); s++) begin
                int eeff, sig, stk, ex, zr, dn, ov, p, lz;
                string req;
                in_valid = 1'b1;
                in_sum   = W_IN'(s);
                in_exp   = EXP_W'(e);
                eeff = (e == 0) ? 1 : e;
                sig = 0; stk = 0; ex = 0; zr = 0; dn = 0; ov = 0;
                if (s == 0) begin
                    req = "R2"; zr = 1;
                end else if (s >= (1 << (W_IN - 1))) begin
                    req = "R3"; sig = (s >> 1) % (1 << W_OUT); stk = s % 2; ex = eeff + 1;
                    if (eeff + 1 >= EMAX) begin req = "R4"; ex = EMAX; ov = 1; end
                end else if (s >= (1 << (W_IN - 2))) begin
                    req = (e == 0) ? "R8" : "R5"; sig = s; ex = eeff;
                end else begin
                    p = 0;
                    while ((s >> (p + 1)) != 0) p++;
                    lz = (W_IN - 2) - p;
                    if (lz <= eeff - 1) begin
                        req = "R6"; sig = (s << lz) % (1 << W_OUT); ex = eeff - lz;
                    end else begin
                        req = (e == 0) ? "R8" : "R7";
                        sig = (s << (eeff - 1)) % (1 << W_OUT); ex = 0; dn = 1;
                    end
                end
                @(negedge clk);
                check_all(req, 1, sig, stk, ex, zr, dn, ov);
                last_sig = sig;
                last_exp = ex;
            end
        end

        // R1: with in_valid low the registered result is held.
        in_valid = 1'b0;
        in_sum   = W_IN'(8'h45);
        in_exp   = EXP_W'(3);
        @(negedge clk);
        checks++;
        if (out_valid != 1'b0 || int'(out_sig) != last_sig || int'(out_exp) != last_exp) begin
            errors++;
            $display("FAIL R1: got v=%0d sig=%0h e=%0d expected v=0 sig=%0h e=%0d",
                     out_valid, out_sig, out_exp, last_sig, last_exp);
        end
        // R9 sanity after hold
        checks++;
        if ((int'(out_zero) + int'(out_denorm) + int'(out_ovf)) > 1) begin
            errors++;
            $display("FAIL R9: got flags z=%0d d=%0d o=%0d expected at most one", out_zero, out_denorm, out_ovf);
        end
        finish_run();
    end
endmodule